// File: doc/BRIEF.md
# UART FIFO Control and Threshold Interrupts

This block is the control side of a UART's transmit and receive FIFO pair. Software writes a one-byte control word through a write strobe. The word turns both FIFOs on or off together. It can clear either FIFO on its own. It also selects coded interrupt thresholds for the receive side and the transmit side. The FIFO storage lives outside the block, which receives the present fill count of each 32-entry FIFO.

From the control word and the counts, the block raises a receive-ready interrupt and a transmit-empty interrupt. The receive interrupt is a level signal that holds while the receive count is at or above its threshold. The transmit interrupt holds while the transmit count is below its threshold.

Four 8-bit programmable level inputs can override the coded thresholds: a receive level, a transmit level, a flow-low level and a flow-high level. As soon as any of the four is nonzero, the receive and transmit thresholds are taken from the receive and transmit level inputs. The coded fields are then ignored.

Top module: `uart_fifo_ctl`

## Requirements
- R1: After reset the stored control byte is 0x00. With `fifo_en` low, both FIFOs are disabled. A write sets `fifo_en` to control bit 0, effective on the clock edge that takes the write.
- R2: A write with bit 1 set produces a one-cycle `rx_clr` pulse in the cycle after the write edge. The stored bit 1 reads back as 0 in the cycle after that.
- R3: A write with bit 2 set produces a one-cycle `tx_clr` pulse in the cycle after the write edge. The stored bit 2 reads back as 0 in the cycle after that.
- R4: Control bit 3 is reserved and has no effect. It always reads back as 0 and changes no output.
- R5: The 2-bit receive code in control bits 7:6 gives a receive threshold of 8, 16, 24 or 28 entries for codes 0, 1, 2 and 3.
- R6: The 2-bit transmit code in control bits 5:4 gives a transmit threshold of 8, 16, 24 or 30 entries for codes 0, 1, 2 and 3.
- R7: `rx_irq` is high exactly when `fifo_en` is high and the receive count is greater than or equal to the receive threshold. It is registered one clock after the inputs it depends on.
- R8: `tx_irq` is high exactly when `fifo_en` is high and the transmit count is strictly less than the transmit threshold. It is registered one clock after its inputs.
- R9: If any of `rx_level`, `tx_level`, `flow_lo_level` or `flow_hi_level` is nonzero, the receive threshold is `rx_level` and the transmit threshold is `tx_level`, and the coded fields are ignored.
- R10: With `fifo_en` low, both interrupts are low whatever the counts and thresholds are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 8 | Control word |
| rx_count | input | 6 | Receive FIFO fill count, 0 to 32 |
| tx_count | input | 6 | Transmit FIFO fill count, 0 to 32 |
| rx_level | input | 8 | Programmable receive threshold |
| tx_level | input | 8 | Programmable transmit threshold |
| flow_lo_level | input | 8 | Programmable flow-low level, used only for override detection |
| flow_hi_level | input | 8 | Programmable flow-high level, used only for override detection |
| rx_clr | output | 1 | One-cycle clear pulse to the receive FIFO |
| tx_clr | output | 1 | One-cycle clear pulse to the transmit FIFO |
| fifo_en | output | 1 | FIFO enable flag |
| ctl_state | output | 8 | Stored control byte as read back |
| rx_irq | output | 1 | Receive-ready interrupt |
| tx_irq | output | 1 | Transmit-empty interrupt |

## Verification
A control write is captured on one edge. The stored byte, `fifo_en` and the clear pulses change right after that edge. The interrupts follow one edge later, because they are registered from the stored byte and the counts. A change in a count or a level input likewise shows on the interrupts one edge later. The bench drives all inputs on falling edges and checks at the falling edge after the edge where each result is due. It checks clear pulses one half-cycle after the write edge and checks that they have dropped a full cycle after that. It sweeps every count from 0 to 32 against every coded threshold. It then repeats the sweep with programmable levels selected through each of the four override inputs.

// File: rtl/uart_fifo_ctl_pkg.sv
package uart_fifo_ctl_pkg;
    localparam int FIFO_DEPTH = 32;
    localparam int CNT_W      = $clog2(FIFO_DEPTH + 1);
    localparam int LVL_W      = 8;

    typedef struct packed {
        logic [1:0] rx_code;
        logic [1:0] tx_code;
        logic       rsvd;
        logic       tx_clr;
        logic       rx_clr;
        logic       en;
    } ctl_t;

    function automatic logic [LVL_W-1:0] rx_code_lvl(input logic [1:0] c);
        case (c)
            2'd0:    return LVL_W'(8);
            2'd1:    return LVL_W'(16);
            2'd2:    return LVL_W'(24);
            default: return LVL_W'(28);
        endcase
    endfunction

    function automatic logic [LVL_W-1:0] tx_code_lvl(input logic [1:0] c);
        case (c)
            2'd0:    return LVL_W'(8);
            2'd1:    return LVL_W'(16);
            2'd2:    return LVL_W'(24);
            default: return LVL_W'(30);
        endcase
    endfunction
endpackage

// File: rtl/ufc_ctl_reg.sv
module ufc_ctl_reg
    import uart_fifo_ctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output ctl_t       ctl_q
);
    ctl_t ctl_d;
    ctl_t ctl_r;

    always_comb begin
        ctl_d        = ctl_r;
        // clear requests self-return after one cycle
        ctl_d.rx_clr = 1'b0;
        ctl_d.tx_clr = 1'b0;
        if (wr_en) begin
            ctl_d.rx_code = wr_data[7:6];
            ctl_d.tx_code = wr_data[5:4];
            ctl_d.rx_clr  = wr_data[1];
            ctl_d.tx_clr  = wr_data[2];
            ctl_d.en      = wr_data[0];
        end
        ctl_d.rsvd = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_r <= '0;
        else        ctl_r <= ctl_d;
    end

    assign ctl_q = ctl_r;
endmodule

// File: rtl/ufc_thresh_sel.sv
module ufc_thresh_sel
    import uart_fifo_ctl_pkg::*;
#(
    parameter int NUM_PROG = 4
) (
    input  ctl_t                    ctl,
    input  logic [NUM_PROG*LVL_W-1:0] prog_lvls,
    input  logic [LVL_W-1:0]        rx_prog,
    input  logic [LVL_W-1:0]        tx_prog,
    output logic [LVL_W-1:0]        rx_thr,
    output logic [LVL_W-1:0]        tx_thr
);
    logic [NUM_PROG-1:0] nz;

    for (genvar g = 0; g < NUM_PROG; g++) begin : g_nz
        assign nz[g] = |prog_lvls[g*LVL_W +: LVL_W];
    end

    always_comb begin
        if (|nz) begin
            rx_thr = rx_prog;
            tx_thr = tx_prog;
        end else begin
            rx_thr = rx_code_lvl(ctl.rx_code);
            tx_thr = tx_code_lvl(ctl.tx_code);
        end
    end
endmodule

// File: rtl/ufc_irq_gen.sv
module ufc_irq_gen
    import uart_fifo_ctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [CNT_W-1:0] rx_count,
    input  logic [CNT_W-1:0] tx_count,
    input  logic [LVL_W-1:0] rx_thr,
    input  logic [LVL_W-1:0] tx_thr,
    output logic             rx_irq,
    output logic             tx_irq
);
    typedef struct packed {
        logic rx;
        logic tx;
    } irq_t;

    irq_t irq_d, irq_q;

    always_comb begin
        irq_d.rx = en && (LVL_W'(rx_count) >= rx_thr);
        irq_d.tx = en && (LVL_W'(tx_count) <  tx_thr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= '0;
        else        irq_q <= irq_d;
    end

    assign rx_irq = irq_q.rx;
    assign tx_irq = irq_q.tx;
endmodule

// File: rtl/uart_fifo_ctl.sv
module uart_fifo_ctl
    import uart_fifo_ctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [7:0]       wr_data,
    input  logic [CNT_W-1:0] rx_count,
    input  logic [CNT_W-1:0] tx_count,
    input  logic [LVL_W-1:0] rx_level,
    input  logic [LVL_W-1:0] tx_level,
    input  logic [LVL_W-1:0] flow_lo_level,
    input  logic [LVL_W-1:0] flow_hi_level,
    output logic             rx_clr,
    output logic             tx_clr,
    output logic             fifo_en,
    output logic [7:0]       ctl_state,
    output logic             rx_irq,
    output logic             tx_irq
);
    ctl_t             ctl;
    logic [LVL_W-1:0] rx_thr, tx_thr;

    ufc_ctl_reg u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .ctl_q   (ctl)
    );

    ufc_thresh_sel #(.NUM_PROG(4)) u_sel (
        .ctl       (ctl),
        .prog_lvls ({flow_hi_level, flow_lo_level, tx_level, rx_level}),
        .rx_prog   (rx_level),
        .tx_prog   (tx_level),
        .rx_thr    (rx_thr),
        .tx_thr    (tx_thr)
    );

    ufc_irq_gen u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (ctl.en),
        .rx_count (rx_count),
        .tx_count (tx_count),
        .rx_thr   (rx_thr),
        .tx_thr   (tx_thr),
        .rx_irq   (rx_irq),
        .tx_irq   (tx_irq)
    );

    assign rx_clr    = ctl.rx_clr;
    assign tx_clr    = ctl.tx_clr;
    assign fifo_en   = ctl.en;
    assign ctl_state = ctl;
endmodule

// File: rtl/uart_fifo_ctl_chk.sv
module uart_fifo_ctl_chk
    import uart_fifo_ctl_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [7:0]       wr_data,
    input logic [CNT_W-1:0] rx_count,
    input logic [CNT_W-1:0] tx_count,
    input logic [LVL_W-1:0] rx_level,
    input logic [LVL_W-1:0] tx_level,
    input logic [LVL_W-1:0] flow_lo_level,
    input logic [LVL_W-1:0] flow_hi_level,
    input logic             rx_clr,
    input logic             tx_clr,
    input logic             fifo_en,
    input logic [7:0]       ctl_state,
    input logic             rx_irq,
    input logic             tx_irq
);
    logic coded;
    assign coded = (rx_level == '0) && (tx_level == '0) &&
                   (flow_lo_level == '0) && (flow_hi_level == '0);

    a_r2_rx_clr_source: assert property (@(posedge clk) disable iff (!rst_n)
        rx_clr |-> $past(wr_en && wr_data[1]));

    a_r2_rx_clr_single: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_clr && !wr_en) |=> !rx_clr);

    a_r3_tx_clr_source: assert property (@(posedge clk) disable iff (!rst_n)
        tx_clr |-> $past(wr_en && wr_data[2]));

    a_r4_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_state[3]);

    a_r10_irq_off: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_en |=> (!rx_irq && !tx_irq));

    a_r7_rx_coded: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_en && coded) |=>
            (rx_irq == (LVL_W'($past(rx_count)) >= rx_code_lvl($past(ctl_state[7:6])))));

    a_r8_tx_coded: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_en && coded) |=>
            (tx_irq == (LVL_W'($past(tx_count)) < tx_code_lvl($past(ctl_state[5:4])))));

    a_r9_rx_prog: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_en && !coded) |=> (rx_irq == (LVL_W'($past(rx_count)) >= $past(rx_level))));
endmodule

bind uart_fifo_ctl uart_fifo_ctl_chk i_chk (.*);

// File: tb/test_uart_fifo_ctl.sv
module test_uart_fifo_ctl;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [5:0] rx_count = '0, tx_count = '0;
    logic [7:0] rx_level = '0, tx_level = '0, flow_lo_level = '0, flow_hi_level = '0;
    logic       rx_clr, tx_clr, fifo_en, rx_irq, tx_irq;
    logic [7:0] ctl_state;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_fifo_ctl i_uart_fifo_ctl (.*);

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // write lands on the next rising edge; returns at the following falling edge
    task automatic wr(input logic [7:0] b);
        @(negedge clk);
        wr_en = 1'b1; wr_data = b;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    function automatic int rx_lvl_of(input int c);
        return (c == 3) ? 28 : (c + 1) * 8;
    endfunction
    function automatic int tx_lvl_of(input int c);
        return (c == 3) ? 30 : (c + 1) * 8;
    endfunction

    task automatic sweep(input int rthr, input int tthr, input logic en, input string tag);
        for (int n = 0; n <= 32; n++) begin
            rx_count = 6'(n); tx_count = 6'(n);
            @(negedge clk);
            chk(rx_irq == (en && n >= rthr), tag, int'(rx_irq), int'(en && n >= rthr));
            chk(tx_irq == (en && n <  tthr), tag, int'(tx_irq), int'(en && n <  tthr));
        end
    endtask

    initial begin
        while (cyc < WATCHDOG) begin
            @(posedge clk);
            cyc++;
        end
        bad++; total++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, WATCHDOG);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(ctl_state == 8'h00, "R1 reset byte", int'(ctl_state), 0);
        chk(!fifo_en, "R1 reset enable", int'(fifo_en), 0);
        chk(!rx_irq && !tx_irq, "R10 reset irqs", int'({rx_irq, tx_irq}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 disabled: counts do nothing
        sweep(0, 0, 1'b0, "R10 disabled");

        // R1 enable
        wr(8'h01);
        chk(fifo_en, "R1 enable set", int'(fifo_en), 1);

        // R2 receive clear pulse
        wr(8'h03);
        chk(rx_clr && !tx_clr, "R2 rx_clr pulse", int'({rx_clr, tx_clr}), 2);
        chk(ctl_state[1], "R2 bit stored", int'(ctl_state), 3);
        @(negedge clk);
        chk(!rx_clr, "R2 rx_clr drop", int'(rx_clr), 0);
        chk(ctl_state == 8'h01, "R2 bit self-clear", int'(ctl_state), 1);

        // R3 transmit clear pulse
        wr(8'h05);
        chk(tx_clr && !rx_clr, "R3 tx_clr pulse", int'({rx_clr, tx_clr}), 1);
        @(negedge clk);
        chk(!tx_clr, "R3 tx_clr drop", int'(tx_clr), 0);
        chk(ctl_state == 8'h01, "R3 bit self-clear", int'(ctl_state), 1);

        // R4 reserved bit ignored
        rx_count = 6'd10; tx_count = 6'd10;
        wr(8'h09);
        @(negedge clk);
        chk(ctl_state == 8'h01, "R4 reserved readback", int'(ctl_state), 1);
        chk(!rx_clr && !tx_clr, "R4 no clears", int'({rx_clr, tx_clr}), 0);
        chk(rx_irq && !tx_irq, "R4 irqs as code 0", int'({rx_irq, tx_irq}), 2);

        // R5 R6 R7 R8: coded thresholds, every pair of codes
        for (int rc = 0; rc < 4; rc++) begin
            for (int tc = 0; tc < 4; tc++) begin
                wr(8'((rc << 6) | (tc << 4) | 1));
                sweep(rx_lvl_of(rc), tx_lvl_of(tc), 1'b1, "R5 R6 R7 R8 coded");
            end
        end

        // R10 disable with counts that would fire
        rx_count = 6'd32; tx_count = 6'd0;
        wr(8'h00);
        @(negedge clk);
        chk(!rx_irq && !tx_irq, "R10 disable forces low", int'({rx_irq, tx_irq}), 0);

        // R9 override through each programmable input
        wr(8'hF1);
        for (int k = 0; k < 4; k++) begin
            rx_level = (k == 0) ? 8'd5 : 8'd0;
            tx_level = (k == 1) ? 8'd12 : 8'd0;
            flow_lo_level = (k == 2) ? 8'd3 : 8'd0;
            flow_hi_level = (k == 3) ? 8'd40 : 8'd0;
            sweep(int'(rx_level), int'(tx_level), 1'b1, "R9 override");
        end
        rx_level = 8'd20; tx_level = 8'd2; flow_lo_level = 8'd0; flow_hi_level = 8'd0;
        sweep(20, 2, 1'b1, "R9 both levels");
        rx_level = 8'd0; tx_level = 8'd0;
        sweep(28, 30, 1'b1, "R9 back to coded");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule